// File: doc/BRIEF.md
# Radix-2 Montgomery Modular Exponentiator

This block raises an operand to a power modulo an odd modulus, Y = X^E mod M, for a parameterized operand width (1024 bits in the target system, smaller for test). All arithmetic is done by one bit-serial radix-2 Montgomery multiplier. A sequencer drives that multiplier through every step of the calculation.

The caller presents X, E, M and the precomputed constant K = 2^(2(WIDTH+2)) mod M while `ready` is high, and pulses `start`. The block captures the operands and then works through the steps below:

- it converts 1 and X into Montgomery form using K;
- it scans the exponent from its least-significant bit, doing a multiply and a square for each bit;
- it leaves Montgomery form with a multiply by 1;
- it reduces the result once into [0, M).

The result is presented on `y` together with a single-cycle `done` pulse. With the constant-time option set, the multiply is issued for every exponent bit and its result is discarded when the bit is 0. The run length then does not depend on E.

Top module: `mexp_core`

## Requirements
- R1: After reset `ready` is 1, `done` is 0 and `y` is 0.
- R2: For an odd modulus M > 1 and X < M, the value on `y` in the `done` cycle equals X^E mod M and is below M.
- R3: An exponent of 0 gives `y` = 1, including when X = 0.
- R4: An exponent of 1 gives `y` = X, including X = 0 and X = M-1.
- R5: `ready` falls in the cycle after an accepted start (`start` and `ready` both 1). A `start` while `ready` is 0 is ignored: the operands of the run in progress decide the result.
- R6: `done` is high for exactly one cycle per run, and `ready` is 1 in that cycle.
- R7: `y` changes only in a cycle where `done` is 1. Between runs it holds its value whatever the inputs do.
- R8: With CONST_TIME = 1, the number of cycles from start to `done` is the same for every exponent and modulus at a given WIDTH.
- R9: Every Montgomery product handed to the sequencer is below 2M. The multiplier takes operands below 2M, iterates WIDTH+2 times and performs no final subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run; accepted when `ready` is 1 |
| x_in | input | WIDTH | Base X, below M |
| e_in | input | WIDTH | Exponent E |
| mod_in | input | WIDTH | Odd modulus M |
| k_in | input | WIDTH | 2^(2(WIDTH+2)) mod M |
| ready | output | 1 | Idle and able to accept `start` |
| done | output | 1 | One-cycle pulse: `y` holds a new result |
| y | output | WIDTH | Result X^E mod M |

## Verification
Directed runs use the following patterns:

- **E = 0 and E = 1** with X = 0 and X = M-1. These separate the initial conversion path from the multiply-select path.
- **All-ones exponent.** Every conditional multiply is taken, which exposes a wrong bit order or a lost multiply.
- **Small modulus near 2^16 and large modulus near 2^32.** These stress the 2M operand bound at both ends of the width.

Random odd moduli of 16 to 32 bits are then run with random bases and exponents. Each result is compared with a square-and-multiply model in the bench. The start-to-done latency of every run is compared with the first run to confirm that it does not depend on E. A second start during a busy run, and input changes after a run, show whether the latched operands and the held result are disturbed.

// File: rtl/mexp_pkg.sv
`timescale 1ns/1ps
package mexp_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_INIT_P,
        SQ_INIT_Z,
        SQ_MUL,
        SQ_SQR,
        SQ_FIN
    } seq_st_e;

endpackage

// File: rtl/mx_montmul.sv
`timescale 1ns/1ps
// Bit-serial radix-2 Montgomery product: p = a*b*2^-(W+2) mod m, result < 2m.
module mx_montmul #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic [W+1:0]   a,
    input  logic [W+1:0]   b,
    input  logic [W-1:0]   m,
    output logic           fin,
    output logic [W+1:0]   p
);
    localparam int ACCW = W + 2;
    localparam int ITER = W + 2;
    localparam int CW   = $clog2(ITER + 1);

    typedef struct packed {
        logic            run;
        logic            fin;
        logic [CW-1:0]   cnt;
        logic [ACCW-1:0] a_sh;
        logic [ACCW-1:0] b;
        logic [W-1:0]    m;
        logic [ACCW-1:0] s;
    } mm_state_t;

    mm_state_t mm_d, mm_q;
    logic [ACCW:0] t_add;
    logic [ACCW:0] t_red;

    always_comb begin
        mm_d     = mm_q;
        mm_d.fin = 1'b0;
        t_add    = {1'b0, mm_q.s} + (mm_q.a_sh[0] ? {1'b0, mm_q.b} : '0);
        t_red    = t_add[0] ? (t_add + {3'b000, mm_q.m}) : t_add;
        if (!mm_q.run) begin
            if (go) begin
                mm_d.run  = 1'b1;
                mm_d.cnt  = '0;
                mm_d.a_sh = a;
                mm_d.b    = b;
                mm_d.m    = m;
                mm_d.s    = '0;
            end
        end else begin
            mm_d.s    = t_red[ACCW:1];
            mm_d.a_sh = {1'b0, mm_q.a_sh[ACCW-1:1]};
            mm_d.cnt  = mm_q.cnt + 1'b1;
            if (mm_q.cnt == CW'(ITER - 1)) begin
                mm_d.run = 1'b0;
                mm_d.fin = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mm_q <= '0;
        else        mm_q <= mm_d;
    end

    assign fin = mm_q.fin;
    assign p   = mm_q.s;

endmodule

// File: rtl/mx_sequencer.sv
`timescale 1ns/1ps
// Exponent scan, least-significant bit first, driving one shared multiplier.
module mx_sequencer
    import mexp_pkg::*;
#(
    parameter int W          = 32,
    parameter bit CONST_TIME = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   x_in,
    input  logic [W-1:0]   e_in,
    input  logic [W-1:0]   mod_in,
    input  logic [W-1:0]   k_in,
    output logic           ready,
    output logic           mm_go,
    output logic [W+1:0]   mm_a,
    output logic [W+1:0]   mm_b,
    input  logic           mm_fin,
    input  logic [W+1:0]   mm_p,
    output logic [W-1:0]   mod_q,
    output logic           res_vld,
    output logic [W+1:0]   res_p
);
    localparam int OPW = W + 2;
    localparam int ECW = $clog2(W + 1);
    localparam logic [OPW-1:0] ONE = OPW'(1);

    typedef struct packed {
        seq_st_e        st;
        logic [ECW-1:0] cnt;
        logic [W-1:0]   x;
        logic [W-1:0]   e;
        logic [W-1:0]   m;
        logic [W-1:0]   k;
        logic [OPW-1:0] p;
        logic [OPW-1:0] z;
    } sq_state_t;

    sq_state_t sq_d, sq_q;
    logic           step_go;
    logic           step_bit;
    logic [OPW-1:0] step_p;
    logic [OPW-1:0] step_z;

    always_comb begin
        sq_d     = sq_q;
        mm_go    = 1'b0;
        mm_a     = '0;
        mm_b     = '0;
        res_vld  = 1'b0;
        res_p    = '0;
        step_go  = 1'b0;
        step_bit = 1'b0;
        step_p   = '0;
        step_z   = '0;
        case (sq_q.st)
            SQ_IDLE: begin
                if (start) begin
                    sq_d.x   = x_in;
                    sq_d.e   = e_in;
                    sq_d.m   = mod_in;
                    sq_d.k   = k_in;
                    sq_d.cnt = '0;
                    sq_d.st  = SQ_LOAD;
                end
            end
            SQ_LOAD: begin
                mm_go   = 1'b1;
                mm_a    = ONE;
                mm_b    = {2'b00, sq_q.k};
                sq_d.st = SQ_INIT_P;
            end
            SQ_INIT_P: begin
                if (mm_fin) begin
                    sq_d.p  = mm_p;
                    mm_go   = 1'b1;
                    mm_a    = {2'b00, sq_q.x};
                    mm_b    = {2'b00, sq_q.k};
                    sq_d.st = SQ_INIT_Z;
                end
            end
            SQ_INIT_Z: begin
                if (mm_fin) begin
                    sq_d.z   = mm_p;
                    step_go  = 1'b1;
                    step_bit = sq_q.e[0];
                    step_p   = sq_q.p;
                    step_z   = mm_p;
                end
            end
            SQ_MUL: begin
                if (mm_fin) begin
                    if (sq_q.e[0]) sq_d.p = mm_p;
                    mm_go   = 1'b1;
                    mm_a    = sq_q.z;
                    mm_b    = sq_q.z;
                    sq_d.st = SQ_SQR;
                end
            end
            SQ_SQR: begin
                if (mm_fin) begin
                    sq_d.z   = mm_p;
                    sq_d.e   = {1'b0, sq_q.e[W-1:1]};
                    sq_d.cnt = sq_q.cnt + 1'b1;
                    if (sq_q.cnt == ECW'(W - 1)) begin
                        mm_go   = 1'b1;
                        mm_a    = sq_q.p;
                        mm_b    = ONE;
                        sq_d.st = SQ_FIN;
                    end else begin
                        step_go  = 1'b1;
                        step_bit = sq_q.e[1];
                        step_p   = sq_q.p;
                        step_z   = mm_p;
                    end
                end
            end
            SQ_FIN: begin
                if (mm_fin) begin
                    res_vld = 1'b1;
                    res_p   = mm_p;
                    sq_d.st = SQ_IDLE;
                end
            end
            default: sq_d.st = SQ_IDLE;
        endcase

        if (step_go) begin
            mm_go = 1'b1;
            if (CONST_TIME || step_bit) begin
                mm_a    = step_p;
                mm_b    = step_z;
                sq_d.st = SQ_MUL;
            end else begin
                mm_a    = step_z;
                mm_b    = step_z;
                sq_d.st = SQ_SQR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '{st: SQ_IDLE, default: '0};
        else        sq_q <= sq_d;
    end

    assign ready = (sq_q.st == SQ_IDLE);
    assign mod_q = sq_q.m;

endmodule

// File: rtl/mx_condsub.sv
`timescale 1ns/1ps
// Single conditional subtraction bringing a value below 2m into [0, m).
module mx_condsub #(
    parameter int W = 32
) (
    input  logic [W+1:0] v,
    input  logic [W-1:0] m,
    output logic [W-1:0] r
);
    logic [W+1:0] diff;

    always_comb begin
        diff = v - {2'b00, m};
        r    = (v >= {2'b00, m}) ? diff[W-1:0] : v[W-1:0];
    end

endmodule

// File: rtl/mexp_core.sv
`timescale 1ns/1ps
module mexp_core #(
    parameter int WIDTH      = 1024,
    parameter bit CONST_TIME = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] x_in,
    input  logic [WIDTH-1:0] e_in,
    input  logic [WIDTH-1:0] mod_in,
    input  logic [WIDTH-1:0] k_in,
    output logic             ready,
    output logic             done,
    output logic [WIDTH-1:0] y
);
    typedef struct packed {
        logic             done;
        logic [WIDTH-1:0] y;
    } out_state_t;

    logic               mm_go, mm_fin, res_vld;
    logic [WIDTH+1:0]   mm_a, mm_b, mm_p, res_p;
    logic [WIDTH-1:0]   mod_q, y_red;
    out_state_t         out_d, out_q;

    mx_sequencer #(.W(WIDTH), .CONST_TIME(CONST_TIME)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .x_in    (x_in),
        .e_in    (e_in),
        .mod_in  (mod_in),
        .k_in    (k_in),
        .ready   (ready),
        .mm_go   (mm_go),
        .mm_a    (mm_a),
        .mm_b    (mm_b),
        .mm_fin  (mm_fin),
        .mm_p    (mm_p),
        .mod_q   (mod_q),
        .res_vld (res_vld),
        .res_p   (res_p)
    );

    mx_montmul #(.W(WIDTH)) u_mm (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mm_go),
        .a     (mm_a),
        .b     (mm_b),
        .m     (mod_q),
        .fin   (mm_fin),
        .p     (mm_p)
    );

    mx_condsub #(.W(WIDTH)) u_red (
        .v (res_p),
        .m (mod_q),
        .r (y_red)
    );

    always_comb begin
        out_d      = out_q;
        out_d.done = res_vld;
        if (res_vld) out_d.y = y_red;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign done = out_q.done;
    assign y    = out_q.y;

endmodule

// File: rtl/mexp_chk.sv
`timescale 1ns/1ps
module mexp_chk #(
    parameter int W = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic           ready,
    input logic           done,
    input logic [W-1:0]   y,
    input logic [W-1:0]   mod_q,
    input logic           mm_fin,
    input logic [W+1:0]   mm_p
);
    assert_y_reduced_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (y < mod_q));

    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    assert_y_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(y) |-> done);

    assert_mm_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mm_fin |-> (mm_p < {1'b0, mod_q, 1'b0}));

endmodule

bind mexp_core mexp_chk #(.W(WIDTH)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ready  (ready),
    .done   (done),
    .y      (y),
    .mod_q  (mod_q),
    .mm_fin (mm_fin),
    .mm_p   (mm_p)
);

// File: tb/sim_mexp_core.sv
`timescale 1ns/1ps
module sim_mexp_core;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] x_in = '0, e_in = '0, mod_in = '0, k_in = '0;
    logic         ready, done;
    logic [W-1:0] y;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    int lat_ref = -1;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    mexp_core #(.WIDTH(W), .CONST_TIME(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .x_in(x_in), .e_in(e_in),
        .mod_in(mod_in), .k_in(k_in), .ready(ready), .done(done), .y(y)
    );

    function automatic logic [W-1:0] k_of(input logic [W-1:0] m);
        logic [63:0] r;
        r = 64'(1) % {32'd0, m};
        for (int i = 0; i < 2 * (W + 2); i++) begin
            r = r << 1;
            if (r >= {32'd0, m}) r = r - {32'd0, m};
        end
        return r[W-1:0];
    endfunction

    function automatic logic [W-1:0] pow_ref(input logic [W-1:0] x,
                                             input logic [W-1:0] e,
                                             input logic [W-1:0] m);
        logic [63:0] r, b, mm;
        mm = {32'd0, m};
        r  = 64'(1) % mm;
        b  = {32'd0, x} % mm;
        for (int i = 0; i < W; i++) begin
            if (e[i]) r = (r * b) % mm;
            b = (b * b) % mm;
        end
        return r[W-1:0];
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Run one exponentiation; optionally pulse start again while busy (R5).
    task automatic run_op(input string tag, input logic [W-1:0] x, input logic [W-1:0] e,
                          input logic [W-1:0] m, input bit poke_busy);
        int lat;
        logic [W-1:0] exp_y;
        exp_y = pow_ref(x, e, m);
        @(negedge clk);
        while (!ready) @(negedge clk);
        x_in = x; e_in = e; mod_in = m; k_in = k_of(m);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        check({tag, " R5 ready low after start"}, {31'd0, ready}, 32'd0);
        if (poke_busy) begin
            x_in = ~x; e_in = ~e; mod_in = m ^ 32'h6;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        while (!done && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
        check({tag, " R2 result"}, y, exp_y);
        check({tag, " R6 ready with done"}, {31'd0, ready}, 32'd1);
        if (lat_ref < 0) lat_ref = lat;
        else check({tag, " R8 latency"}, lat, lat_ref);
        // R7: scramble inputs without start; y must hold, done must drop (R6)
        x_in = $urandom; e_in = $urandom; mod_in = $urandom; k_in = $urandom;
        @(negedge clk);
        check({tag, " R6 done one cycle"}, {31'd0, done}, 32'd0);
        repeat (3) @(negedge clk);
        check({tag, " R7 y held"}, y, exp_y);
    endtask

    initial begin
        logic [W-1:0] m, x, e, mask;
        int bits;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1 ready at reset", {31'd0, ready}, 32'd1);
        check("R1 done at reset", {31'd0, done}, 32'd0);
        check("R1 y at reset", y, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op("R3 e=0",          32'd1234,      32'd0, 32'd65521, 1'b0);
        run_op("R3 e=0 x=0",      32'd0,         32'd0, 32'hFFFF_FFFB, 1'b0);
        run_op("R4 e=1",          32'd4321,      32'd1, 32'd65521, 1'b0);
        run_op("R4 e=1 x=m-1",    32'hFFFF_FFFA, 32'd1, 32'hFFFF_FFFB, 1'b0);
        run_op("R4 e=1 x=0",      32'd0,         32'd1, 32'd40961, 1'b0);
        run_op("R2 e=all ones",   32'h1234_5678, 32'hFFFF_FFFF, 32'hFFFF_FFFB, 1'b0);
        run_op("R2 x=m-1 e=2",    32'd65520,     32'd2, 32'd65521, 1'b0);
        run_op("R5 busy start",   32'hABCDE,     32'h00F0_0F0F, 32'h8000_0001, 1'b1);

        for (int i = 0; i < 20; i++) begin
            bits = 16 + int'($urandom % 17);
            mask = (bits == 32) ? 32'hFFFF_FFFF : ((32'd1 << bits) - 32'd1);
            m = ($urandom & mask) | (32'd1 << (bits - 1)) | 32'd1;
            x = $urandom % m;
            e = $urandom;
            run_op("R2 random", x, e, m, 1'b0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cycles >= 190000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2 actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule